// File: doc/BRIEF.md
# Arrayed Register Address Decoder

This block converts one CPU access request into per-register access strobes for a register map that contains both single registers and multidimensional register arrays. A request is a single-cycle valid flag plus a byte address relative to the start of the map. The block is purely combinational. In the cycle the request is presented, it raises exactly one strobe for the register instance whose address matches. If nothing matches, it raises a miss flag instead. A later stage can turn the miss flag into an error response.

Every register position is given as an absolute address. The block subtracts the map's base address from it, so matching is done relative to the block. An array element's address is its array's relative base plus one index-times-stride term per dimension. Strides are built from the innermost dimension outward. The default map has two single registers, a one-dimensional array and a two-dimensional array. Registers are four bytes wide.

Top module: `regArrayDecoder`

## Requirements
- R1: With `reqValid` high, the address equal to the control register's relative offset (default 0x000) raises `strbCtrl`. The address equal to the status register's relative offset (default 0x004) raises `strbStat`. Both strobes appear in the same cycle as the request.
- R2: While `reqValid` is low, every strobe and `miss` are low, whatever the address.
- R3: Each register's relative offset equals its absolute address minus `MAP_BASE`. With the defaults (base 0x20000; registers at 0x20000, 0x20004, 0x20010, 0x20040), the relative offsets are 0x000, 0x004, 0x010 and 0x040.
- R4: Vector element k (0..VEC_N-1, default 4 elements) is selected by relative address 0x010 + 4*k. It drives bit k of `strbVec`.
- R5: Grid element (row r, column c), with default 3 rows and 5 columns, is selected by relative address 0x040 + r*20 + c*4. The column stride is the register size, and the row stride is the column stride times the column count. The element drives bit r*GRID_COLS + c of `strbGrid`.
- R6: With `reqValid` high, an address that is not a multiple of 4 raises no strobe and raises `miss`.
- R7: With `reqValid` high, an aligned address that belongs to no register raises no strobe and raises `miss`.
- R8: Across all strobe outputs, at most one bit is high in any cycle.
- R9: `miss` is never high together with any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reqValid | input | 1 | Access request present this cycle |
| reqAddr | input | ADDR_W (12) | Byte address relative to the map base |
| strbCtrl | output | 1 | Strobe for the control register |
| strbStat | output | 1 | Strobe for the status register |
| strbVec | output | VEC_N (4) | Strobes for the one-dimensional array, bit k = element k |
| strbGrid | output | GRID_ROWS*GRID_COLS (15) | Strobes for the two-dimensional array, bit r*GRID_COLS+c |
| miss | output | 1 | Valid request that matched no register |

## Verification
Two functions meet on the same request: the strobe path and the miss path. Both are driven by one `reqValid` and one address, so every address raises exactly one of them. A full sweep of the 4096-entry address space with `reqValid` high provokes this. It crosses every array boundary, every unaligned offset and every hole in the map. Each result is judged against a model that finds the index by subtracting and dividing, not by comparing for equality. A second sweep with `reqValid` low confirms that both paths stay silent.

// File: rtl/regDecPkg.sv
`timescale 1ns/1ps
package regDecPkg;

  // Gate control handed from the control module to the datapath
  typedef struct packed {
    logic fire;   // request present: let matches through
    logic miss;   // request present but nothing matched
  } gateCtl_t;

  // Stride of one array dimension: element size times the product of
  // all dimensions inside it (innermost first)
  function automatic int unsigned dimStride(int unsigned elemBytes,
                                            int unsigned innerCount);
    return elemBytes * innerCount;
  endfunction

endpackage

// File: rtl/regDecCell.sv
`timescale 1ns/1ps
module regDecCell #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MATCH_OFS = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] MATCH_ADDR = ADDR_W'(MATCH_OFS);

  assign hit = (addr == MATCH_ADDR);
endmodule

// File: rtl/regDecMatch.sv
`timescale 1ns/1ps
module regDecMatch
  import regDecPkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned REG_BYTES = 4,
  parameter int unsigned CTRL_REL  = 32'h000,
  parameter int unsigned STAT_REL  = 32'h004,
  parameter int unsigned VEC_REL   = 32'h010,
  parameter int unsigned VEC_N     = 4,
  parameter int unsigned GRID_REL  = 32'h040,
  parameter int unsigned GRID_ROWS = 3,
  parameter int unsigned GRID_COLS = 5
) (
  input  logic [ADDR_W-1:0]              addr,
  input  gateCtl_t                       ctl,
  output logic                           hitAny,
  output logic                           strbCtrl,
  output logic                           strbStat,
  output logic [VEC_N-1:0]               strbVec,
  output logic [GRID_ROWS*GRID_COLS-1:0] strbGrid
);
  localparam int unsigned GRID_N          = GRID_ROWS * GRID_COLS;
  localparam int unsigned TOTAL           = 2 + VEC_N + GRID_N;
  localparam int unsigned VEC_STRIDE      = dimStride(REG_BYTES, 1);
  localparam int unsigned GRID_COL_STRIDE = dimStride(REG_BYTES, 1);
  localparam int unsigned GRID_ROW_STRIDE = dimStride(REG_BYTES, GRID_COLS);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(REG_BYTES - 1);

  logic [TOTAL-1:0] hitRaw;

  regDecCell #(.ADDR_W(ADDR_W), .MATCH_OFS(CTRL_REL)) i_ctrlCell (
    .addr(addr), .hit(hitRaw[0]));
  regDecCell #(.ADDR_W(ADDR_W), .MATCH_OFS(STAT_REL)) i_statCell (
    .addr(addr), .hit(hitRaw[1]));

  for (genvar k = 0; k < VEC_N; k++) begin : g_vec
    regDecCell #(
      .ADDR_W(ADDR_W),
      .MATCH_OFS(VEC_REL + k * VEC_STRIDE)
    ) i_vecCell (.addr(addr), .hit(hitRaw[2 + k]));
  end

  for (genvar r = 0; r < GRID_ROWS; r++) begin : g_row
    for (genvar c = 0; c < GRID_COLS; c++) begin : g_col
      regDecCell #(
        .ADDR_W(ADDR_W),
        .MATCH_OFS(GRID_REL + r * GRID_ROW_STRIDE + c * GRID_COL_STRIDE)
      ) i_gridCell (.addr(addr), .hit(hitRaw[2 + VEC_N + r * GRID_COLS + c]));
    end
  end

  assign hitAny = |hitRaw;

  logic [TOTAL-1:0] gated;
  assign gated    = hitRaw & {TOTAL{ctl.fire}};
  assign strbCtrl = gated[0];
  assign strbStat = gated[1];
  assign strbVec  = gated[2 +: VEC_N];
  assign strbGrid = gated[2 + VEC_N +: GRID_N];

  always_comb begin
    a_r6_unaligned_no_hit: assert (((addr & ALIGN_MASK) == '0) || (hitRaw == '0))
      else $error("unaligned address matched a register");
    a_r8_raw_onehot: assert ($onehot0(hitRaw))
      else $error("overlapping register addresses");
  end
endmodule

// File: rtl/regDecGate.sv
`timescale 1ns/1ps
module regDecGate
  import regDecPkg::*;
(
  input  logic     reqValid,
  input  logic     hitAny,
  output gateCtl_t ctl
);
  always_comb begin
    ctl.fire = reqValid;
    ctl.miss = reqValid & ~hitAny;
  end
endmodule

// File: rtl/regArrayDecoder.sv
`timescale 1ns/1ps
module regArrayDecoder
  import regDecPkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned REG_BYTES = 4,
  parameter int unsigned MAP_BASE  = 32'h0002_0000,
  parameter int unsigned CTRL_ABS  = 32'h0002_0000,
  parameter int unsigned STAT_ABS  = 32'h0002_0004,
  parameter int unsigned VEC_ABS   = 32'h0002_0010,
  parameter int unsigned VEC_N     = 4,
  parameter int unsigned GRID_ABS  = 32'h0002_0040,
  parameter int unsigned GRID_ROWS = 3,
  parameter int unsigned GRID_COLS = 5
) (
  input  logic                           reqValid,
  input  logic [ADDR_W-1:0]              reqAddr,
  output logic                           strbCtrl,
  output logic                           strbStat,
  output logic [VEC_N-1:0]               strbVec,
  output logic [GRID_ROWS*GRID_COLS-1:0] strbGrid,
  output logic                           miss
);
  // Decoding is relative to the map base
  localparam int unsigned CTRL_REL = CTRL_ABS - MAP_BASE;
  localparam int unsigned STAT_REL = STAT_ABS - MAP_BASE;
  localparam int unsigned VEC_REL  = VEC_ABS  - MAP_BASE;
  localparam int unsigned GRID_REL = GRID_ABS - MAP_BASE;

  gateCtl_t ctl;
  logic     hitAny;

  regDecGate i_gate (
    .reqValid(reqValid),
    .hitAny  (hitAny),
    .ctl     (ctl)
  );

  regDecMatch #(
    .ADDR_W(ADDR_W), .REG_BYTES(REG_BYTES),
    .CTRL_REL(CTRL_REL), .STAT_REL(STAT_REL),
    .VEC_REL(VEC_REL), .VEC_N(VEC_N),
    .GRID_REL(GRID_REL), .GRID_ROWS(GRID_ROWS), .GRID_COLS(GRID_COLS)
  ) i_match (
    .addr    (reqAddr),
    .ctl     (ctl),
    .hitAny  (hitAny),
    .strbCtrl(strbCtrl),
    .strbStat(strbStat),
    .strbVec (strbVec),
    .strbGrid(strbGrid)
  );

  assign miss = ctl.miss;

  logic anyStrb;
  assign anyStrb = strbCtrl | strbStat | (|strbVec) | (|strbGrid);

  always_comb begin
    a_r2_idle_quiet: assert (reqValid || (!anyStrb && !miss))
      else $error("output active without a request");
    a_r8_out_onehot: assert ($onehot0({strbGrid, strbVec, strbStat, strbCtrl}))
      else $error("more than one strobe high");
    a_r9_miss_exclusive: assert (!(miss && anyStrb))
      else $error("miss together with a strobe");
    a_r7_valid_resolves: assert (!reqValid || (miss ^ anyStrb))
      else $error("valid request neither hit nor missed");
  end
endmodule

// File: tb/test_regArrayDecoder.sv
`timescale 1ns/1ps
module test_regArrayDecoder;
  localparam int ADDR_W = 12;
  localparam int VEC_N  = 4;
  localparam int ROWS   = 3;
  localparam int COLS   = 5;
  localparam int TOT    = 2 + VEC_N + ROWS * COLS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic                 reqValid = 1'b0;
  logic [ADDR_W-1:0]    reqAddr  = '0;
  logic                 strbCtrl, strbStat, miss;
  logic [VEC_N-1:0]     strbVec;
  logic [ROWS*COLS-1:0] strbGrid;

  regArrayDecoder i_regArrayDecoder (
    .reqValid(reqValid), .reqAddr(reqAddr),
    .strbCtrl(strbCtrl), .strbStat(strbStat),
    .strbVec(strbVec), .strbGrid(strbGrid), .miss(miss)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              v;
    logic [TOT-1:0]    expStrb;
    logic              expMiss;
    string             tag;
  } item_t;

  item_t scoreQ[$];
  int total = 0;
  int passed = 0;
  bit done = 0;

  // Independent model: subtract and divide, no equality table
  function automatic logic [TOT-1:0] model(logic v, logic [ADDR_W-1:0] a);
    logic [TOT-1:0] e = '0;
    int off = int'(a);
    if (!v || (off % 4) != 0) return e;
    if (off == 0) e[0] = 1'b1;
    else if (off == 4) e[1] = 1'b1;
    else if (off >= 16 && off < 16 + 4 * VEC_N) e[2 + (off - 16) / 4] = 1'b1;
    else if (off >= 64 && off < 64 + 4 * ROWS * COLS) begin
      int row = (off - 64) / (4 * COLS);
      int col = ((off - 64) % (4 * COLS)) / 4;
      e[2 + VEC_N + row * COLS + col] = 1'b1;
    end
    return e;
  endfunction

  task automatic drive(logic v, logic [ADDR_W-1:0] a, string tag);
    item_t it;
    @(posedge clk);
    reqValid <= v;
    reqAddr  <= a;
    it.addr = a; it.v = v; it.tag = tag;
    it.expStrb = model(v, a);
    it.expMiss = v && (model(v, a) == '0);
    scoreQ.push_back(it);
  endtask

  // Monitor: sample away from the active edge
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      item_t it;
      logic [TOT-1:0] got;
      it = scoreQ.pop_front();
      got = {strbGrid, strbVec, strbStat, strbCtrl};
      total++;
      if (got === it.expStrb && miss === it.expMiss) passed++;
      else $display("FAIL %s addr=%h v=%0b strobes=%h miss=%0b expected strobes=%h miss=%0b",
                    it.tag, it.addr, it.v, got, miss, it.expStrb, it.expMiss);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;   // reset state, request idle (R2)
    if ({strbGrid, strbVec, strbStat, strbCtrl} === '0 && miss === 1'b0) passed++;
    else $display("FAIL R2 reset strobes=%h miss=%0b expected 0 0",
                  {strbGrid, strbVec, strbStat, strbCtrl}, miss);
    rstN = 1'b1;

    drive(1'b1, 12'h000, "R1 ctrl / R3 relative base");
    drive(1'b1, 12'h004, "R1 stat");
    drive(1'b1, 12'h010, "R4 vec[0]");
    drive(1'b1, 12'h01C, "R4 vec[last]");
    drive(1'b1, 12'h020, "R7 past vec end");
    drive(1'b1, 12'h040, "R5 grid(0,0)");
    drive(1'b1, 12'h054, "R5 grid(1,0) row stride");
    drive(1'b1, 12'h078, "R5 grid(2,4)");
    drive(1'b1, 12'h07C, "R7 past grid end");
    drive(1'b1, 12'h042, "R6 unaligned in grid");
    drive(1'b1, 12'h005, "R6 unaligned stat");
    drive(1'b0, 12'h040, "R2 idle on grid address");
    drive(1'b1, 12'hFFC, "R7 top of space");

    for (int a = 0; a < (1 << ADDR_W); a++)
      drive(1'b1, ADDR_W'(a), "R8/R9 sweep");
    for (int a = 0; a < 256; a++)
      drive(1'b0, ADDR_W'(a), "R2 idle sweep");

    @(posedge clk);
    reqValid <= 1'b0;
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end
endmodule